// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Hunt-Mode Wakeup

This block receives asynchronous serial characters from a single line, using an external oversampling enable that pulses sixteen times per bit period. It confirms a start bit at its midpoint and then samples every later bit at its midpoint. It assembles seven or eight data bits, least significant first. An optional parity bit is checked in odd or even sense, and one or two stop bits are checked. Each finished character is presented on a parallel output with a one-cycle valid strobe and three flags: address, parity error and framing error.

The receiver has a sleeping hunt state. It is in hunt after reset and returns to it whenever the enter-hunt command is pulsed. While it sleeps, completed characters are thrown away. How it wakes depends on the configured mode. In point-to-point mode it wakes once the line has stayed high for the length of one whole idle character. In multidrop mode every character carries an extra bit after the data, and the receiver wakes on the first character whose extra bit is 1. That address character is delivered. Software uses the hunt command to skip the rest of a message, or to ignore traffic meant for other stations.

Top module: `uart_hunt_rx`

## Requirements
- R1: After reset the outputs are zero and the receiver is in hunt. A character sent at once after reset, before a full idle run, is not delivered.
- R2: Characters are assembled least significant bit first. With `cfgLongChar`=1 there are 8 data bits. With `cfgLongChar`=0 there are 7, and `rxData[7]` reads 0.
- R3: With `cfgParityEn`=1, a parity bit follows the data bits and the multidrop address bit. `cfgParityEven`=0 requires an odd total of ones over those bits plus the parity bit; `cfgParityEven`=1 requires an even total. A mismatch sets `rxParityErr` on that character.
- R4: With `cfgParityEn`=0 no parity bit is expected, and `rxParityErr` stays 0.
- R5: A low level at a stop-bit sample sets `rxFrameErr`, and the character is still delivered. No new start bit is then looked for until the line has been seen high, so a line held low makes no second character.
- R6: In point-to-point mode (`cfgMultidrop`=0), a sleeping receiver wakes after the line has been high for 1 + data bits + parity bit (if enabled) + stop bits bit times, counted from the last low level or hunt command. That is 9 bit times for 7 data bits with no parity and one stop bit, and 12 for 8 data bits with parity and two stops. A shorter run does not wake it.
- R7: In multidrop mode a sleeping receiver ignores idle runs and discards characters whose address bit is 0. A character whose address bit is 1 wakes it and is delivered with `rxAddr`=1.
- R8: In multidrop mode an awake receiver delivers every character, with `rxAddr` equal to its address bit. In point-to-point mode `rxAddr` is always 0.
- R9: A pulse on `enterHunt` puts an awake receiver back into hunt, and the next character is discarded.
- R10: With `cfgTwoStop`=1 both stop bits are checked, and a low second stop bit sets `rxFrameErr`.
- R11: `rxValid` is high for a single clock per delivered character. The data and flags hold their values until the next delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Serial line, idle high |
| enterHunt | input | 1 | One-cycle command to return to hunt |
| cfgLongChar | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfgParityEn | input | 1 | Parity bit present and checked |
| cfgParityEven | input | 1 | 1: even parity, 0: odd parity |
| cfgTwoStop | input | 1 | 1: two stop bits, 0: one |
| cfgMultidrop | input | 1 | 1: address-bit mode, 0: point-to-point |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | One-cycle delivery strobe |
| rxAddr | output | 1 | Character is an address (multidrop) |
| rxParityErr | output | 1 | Parity mismatch on this character |
| rxFrameErr | output | 1 | Stop bit sampled low |

## Verification
The hardest condition to reach from the ports is the edge of the idle-run wake. The line has to stay high for just under, and then just over, the threshold, and that run must begin at a known point. The stimulus pulses `enterHunt`, which restarts the idle count, and then holds the line high for a chosen whole number of bit times before sending a probe character. Whether that probe is delivered shows whether the receiver woke. This is done at the shortest and the longest threshold, one bit time on either side of each.

// File: rtl/uart_hunt_rx_pkg.sv
package uart_hunt_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_ADDR,
    ST_PAR,
    ST_STOP,
    ST_DONE,
    ST_WAITHI
  } rxState_e;

  typedef struct packed {
    logic clear;
    logic shiftBit;
    logic takeAddr;
    logic takeParity;
    logic takeStop;
    logic deliver;
  } rxStrobes_t;

endpackage

// File: rtl/uart_hunt_rx_ctrl.sv
module uart_hunt_rx_ctrl
  import uart_hunt_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxd,
  input  logic       enterHunt,
  input  logic       cfgLongChar,
  input  logic       cfgParityEn,
  input  logic       cfgTwoStop,
  input  logic       cfgMultidrop,
  input  logic       dpAddrBit,
  output logic       rxBit,
  output rxStrobes_t stb
);

  localparam int TICK_W = $clog2(TICKS_PER_BIT);
  localparam int HALF   = TICKS_PER_BIT / 2;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int IDLE_W = $clog2(DATA_W + 6);
  localparam logic [TICK_W-1:0] MID_TICK  = TICK_W'(HALF - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0]  LAST_LONG  = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0]  LAST_SHORT = BIT_W'(DATA_W - 2);
  localparam logic [IDLE_W-1:0] IDLE_SAT   = '1;

  logic [1:0]        syncQ;
  rxState_e          stateQ, stateD;
  logic [TICK_W-1:0] tickCnt, tickD;
  logic [BIT_W-1:0]  bitCnt, bitD;
  logic              stopCnt, stopD;
  logic              stopLowQ, stopLowD;
  logic [TICK_W-1:0] idleTicks;
  logic [IDLE_W-1:0] idleBits;
  logic [IDLE_W-1:0] idleThresh;
  logic              hunting;
  logic              bitEnd;
  logic [BIT_W-1:0]  lastIdx;

  // two-flop synchronizer for the asynchronous line
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxd};
  end
  assign rxBit = syncQ[1];

  assign bitEnd  = tick && (tickCnt == LAST_TICK);
  assign lastIdx = cfgLongChar ? LAST_LONG : LAST_SHORT;

  always_comb begin
    stateD   = stateQ;
    tickD    = tickCnt;
    bitD     = bitCnt;
    stopD    = stopCnt;
    stopLowD = stopLowQ;
    stb      = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (tick && !rxBit) begin
          stateD = ST_START;
          tickD  = '0;
        end
      end
      ST_START: begin
        if (tick) begin
          tickD = tickCnt + 1'b1;
          if (tickCnt == MID_TICK) begin
            if (!rxBit) begin
              stateD    = ST_DATA;
              tickD     = '0;
              bitD      = '0;
              stopLowD  = 1'b0;
              stb.clear = 1'b1;
            end else begin
              stateD = ST_IDLE;
            end
          end
        end
      end
      ST_DATA: begin
        if (tick) tickD = tickCnt + 1'b1;
        if (bitEnd) begin
          tickD        = '0;
          stb.shiftBit = 1'b1;
          bitD         = bitCnt + 1'b1;
          stopD        = 1'b0;
          if (bitCnt == lastIdx)
            stateD = cfgMultidrop ? ST_ADDR : (cfgParityEn ? ST_PAR : ST_STOP);
        end
      end
      ST_ADDR: begin
        if (tick) tickD = tickCnt + 1'b1;
        if (bitEnd) begin
          tickD        = '0;
          stb.takeAddr = 1'b1;
          stateD       = cfgParityEn ? ST_PAR : ST_STOP;
        end
      end
      ST_PAR: begin
        if (tick) tickD = tickCnt + 1'b1;
        if (bitEnd) begin
          tickD          = '0;
          stb.takeParity = 1'b1;
          stateD         = ST_STOP;
        end
      end
      ST_STOP: begin
        if (tick) tickD = tickCnt + 1'b1;
        if (bitEnd) begin
          tickD        = '0;
          stb.takeStop = 1'b1;
          if (!rxBit) begin
            stopLowD = 1'b1;
            stateD   = ST_DONE;
          end else if (stopCnt == cfgTwoStop) begin
            stateD = ST_DONE;
          end else begin
            stopD = 1'b1;
          end
        end
      end
      ST_DONE: begin
        stb.deliver = !hunting || (cfgMultidrop && dpAddrBit);
        stateD      = stopLowQ ? ST_WAITHI : ST_IDLE;
      end
      ST_WAITHI: begin
        if (tick && rxBit) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      tickCnt  <= '0;
      bitCnt   <= '0;
      stopCnt  <= 1'b0;
      stopLowQ <= 1'b0;
    end else begin
      stateQ   <= stateD;
      tickCnt  <= tickD;
      bitCnt   <= bitD;
      stopCnt  <= stopD;
      stopLowQ <= stopLowD;
    end
  end

  // idle-run measurement in whole bit times, saturating
  assign idleThresh = IDLE_W'(1) + (cfgLongChar ? IDLE_W'(DATA_W) : IDLE_W'(DATA_W - 1))
                    + IDLE_W'(cfgParityEn) + (cfgTwoStop ? IDLE_W'(2) : IDLE_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || enterHunt || (tick && !rxBit)) begin
      idleTicks <= '0;
      idleBits  <= '0;
    end else if (tick && (idleBits != IDLE_SAT)) begin
      idleTicks <= idleTicks + 1'b1;
      if (idleTicks == LAST_TICK) idleBits <= idleBits + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      hunting <= 1'b1;
    else if (enterHunt)
      hunting <= 1'b1;
    else if (hunting && cfgMultidrop && (stateQ == ST_DONE) && dpAddrBit)
      hunting <= 1'b0;
    else if (hunting && !cfgMultidrop && (idleBits >= idleThresh))
      hunting <= 1'b0;
  end

  // R9: the hunt command always leaves the receiver asleep
  a_r9_hunt_cmd: assert property (@(posedge clk) disable iff (!rstN)
    enterHunt |=> hunting);

  // R7: in multidrop mode only a finished character can end the hunt
  a_r7_md_wake_frame: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(hunting) && $past(cfgMultidrop)) |-> $past(stateQ == ST_DONE));

  // R5: a low line never restarts reception after a framing error
  a_r5_wait_high: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_WAITHI && !rxBit) |=> (stateQ == ST_WAITHI));

endmodule

// File: rtl/uart_hunt_rx_dp.sv
module uart_hunt_rx_dp
  import uart_hunt_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobes_t        stb,
  input  logic              rxBit,
  input  logic              cfgLongChar,
  input  logic              cfgParityEn,
  input  logic              cfgParityEven,
  input  logic              cfgMultidrop,
  output logic              dpAddrBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxAddr,
  output logic              rxParityErr,
  output logic              rxFrameErr
);

  logic [DATA_W-1:0] shiftQ;
  logic              parAcc;
  logic              addrQ;
  logic              perrQ;
  logic              ferrQ;

  assign dpAddrBit = addrQ;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      shiftQ <= '0;
      parAcc <= 1'b0;
      addrQ  <= 1'b0;
      perrQ  <= 1'b0;
      ferrQ  <= 1'b0;
    end else begin
      if (stb.shiftBit) begin
        shiftQ <= {rxBit, shiftQ[DATA_W-1:1]};
        parAcc <= parAcc ^ rxBit;
      end
      if (stb.takeAddr) begin
        addrQ  <= rxBit;
        parAcc <= parAcc ^ rxBit;
      end
      if (stb.takeParity)
        perrQ <= cfgParityEn && (parAcc ^ rxBit ^ !cfgParityEven);
      if (stb.takeStop && !rxBit)
        ferrQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData      <= '0;
      rxValid     <= 1'b0;
      rxAddr      <= 1'b0;
      rxParityErr <= 1'b0;
      rxFrameErr  <= 1'b0;
    end else begin
      rxValid <= stb.deliver;
      if (stb.deliver) begin
        rxData      <= cfgLongChar ? shiftQ : (shiftQ >> 1);
        rxAddr      <= cfgMultidrop && addrQ;
        rxParityErr <= perrQ;
        rxFrameErr  <= ferrQ;
      end
    end
  end

  // R11: a delivery strobe lasts one clock
  a_r11_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R11: delivered data holds between strobes
  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.deliver |=> $stable(rxData));

  // R4: parity errors only appear when parity is enabled
  a_r4_perr_needs_pen: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !cfgParityEn) |-> !rxParityErr);

  // R8: the address flag is only raised in multidrop mode
  a_r8_addr_needs_md: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxAddr) |-> cfgMultidrop);

endmodule

// File: rtl/uart_hunt_rx.sv
module uart_hunt_rx
  import uart_hunt_rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxd,
  input  logic              enterHunt,
  input  logic              cfgLongChar,
  input  logic              cfgParityEn,
  input  logic              cfgParityEven,
  input  logic              cfgTwoStop,
  input  logic              cfgMultidrop,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxAddr,
  output logic              rxParityErr,
  output logic              rxFrameErr
);

  rxStrobes_t stb;
  logic       rxBit;
  logic       dpAddrBit;

  uart_hunt_rx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .tick        (tick),
    .rxd         (rxd),
    .enterHunt   (enterHunt),
    .cfgLongChar (cfgLongChar),
    .cfgParityEn (cfgParityEn),
    .cfgTwoStop  (cfgTwoStop),
    .cfgMultidrop(cfgMultidrop),
    .dpAddrBit   (dpAddrBit),
    .rxBit       (rxBit),
    .stb         (stb)
  );

  uart_hunt_rx_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rxBit        (rxBit),
    .cfgLongChar  (cfgLongChar),
    .cfgParityEn  (cfgParityEn),
    .cfgParityEven(cfgParityEven),
    .cfgMultidrop (cfgMultidrop),
    .dpAddrBit    (dpAddrBit),
    .rxData       (rxData),
    .rxValid      (rxValid),
    .rxAddr       (rxAddr),
    .rxParityErr  (rxParityErr),
    .rxFrameErr   (rxFrameErr)
  );

endmodule

// File: tb/sim_uart_hunt_rx.sv
module sim_uart_hunt_rx;

  localparam int BIT_CLKS = 32;   // 16 ticks, one tick every other clock

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic       enterHunt = 1'b0;
  logic       cfgLongChar = 1'b1;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityEven = 1'b0;
  logic       cfgTwoStop = 1'b0;
  logic       cfgMultidrop = 1'b0;
  logic [7:0] rxData;
  logic       rxValid, rxAddr, rxParityErr, rxFrameErr;

  int errors = 0;
  int checks = 0;
  int gotCount = 0;
  int pulseBad = 0;
  logic prevValid = 1'b0;
  logic [7:0] gotData = '0;
  logic gotAddr = 1'b0, gotPerr = 1'b0, gotFerr = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) tick <= !tick;

  uart_hunt_rx u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .rxd(rxd), .enterHunt(enterHunt),
    .cfgLongChar(cfgLongChar), .cfgParityEn(cfgParityEn),
    .cfgParityEven(cfgParityEven), .cfgTwoStop(cfgTwoStop),
    .cfgMultidrop(cfgMultidrop), .rxData(rxData), .rxValid(rxValid),
    .rxAddr(rxAddr), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      gotCount <= gotCount + 1;
      gotData  <= rxData;
      gotAddr  <= rxAddr;
      gotPerr  <= rxParityErr;
      gotFerr  <= rxFrameErr;
      if (prevValid) pulseBad <= pulseBad + 1;
    end
    prevValid <= rxValid;
  end

  // vector: {long, pen, even, two, data[7:0], flipParity, badStop}
  localparam int NV = 9;
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h3D, 1'b1, 1'b0},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b1, 1'b0, 8'h7F, 1'b1, 1'b0},
    {1'b1, 1'b0, 1'b0, 1'b1, 8'h66, 1'b0, 1'b1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h18, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bitWait(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic sendIdle(input int n);
    rxd = 1'b1;
    bitWait(n);
  endtask

  task automatic pulseHunt();
    @(negedge clk) enterHunt = 1'b1;
    @(negedge clk) enterHunt = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input logic addrBit,
                           input logic flip, input logic badStop);
    int len;
    logic ones;
    int nStop;
    len   = cfgLongChar ? 8 : 7;
    nStop = cfgTwoStop ? 2 : 1;
    ones  = 1'b0;
    @(negedge clk) rxd = 1'b0;
    bitWait(1);
    for (int i = 0; i < len; i++) begin
      rxd = d[i];
      ones ^= d[i];
      bitWait(1);
    end
    if (cfgMultidrop) begin
      rxd = addrBit;
      ones ^= addrBit;
      bitWait(1);
    end
    if (cfgParityEn) begin
      rxd = (cfgParityEven ? ones : !ones) ^ flip;
      bitWait(1);
    end
    for (int s = 0; s < nStop; s++) begin
      rxd = !(badStop && (s == nStop - 1));
      bitWait(1);
    end
    rxd = 1'b1;
  endtask

  task automatic expectOne(input string req, input int cnt0, input logic [7:0] d,
                           input logic a, input logic pe, input logic fe);
    check(req, gotCount == cnt0 + 1, gotCount - cnt0, 1);
    check(req, gotData == d, gotData, d);
    check(req, {gotAddr, gotPerr, gotFerr} == {a, pe, fe},
          {gotAddr, gotPerr, gotFerr}, {a, pe, fe});
  endtask

  task automatic expectNone(input string req, input int cnt0);
    check(req, gotCount == cnt0, gotCount - cnt0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0;
    logic [7:0] expD;
    repeat (5) @(negedge clk);
    // R1: reset values
    check("R1", {rxValid, rxAddr, rxParityErr, rxFrameErr, rxData} == 12'h0,
          {rxValid, rxAddr, rxParityErr, rxFrameErr, rxData}, 0);
    rstN = 1'b1;
    // R1: hunt after reset, a frame with no idle run is dropped
    c0 = gotCount;
    sendFrame(8'h55, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectNone("R1", c0);
    sendIdle(14);

    // R2 R3 R4 R5 R10: table of awake point-to-point characters
    for (int v = 0; v < NV; v++) begin
      {cfgLongChar, cfgParityEn, cfgParityEven, cfgTwoStop} = VEC[v][13:10];
      expD = cfgLongChar ? VEC[v][9:2] : (VEC[v][9:2] & 8'h7F);
      c0 = gotCount;
      sendFrame(VEC[v][9:2], 1'b0, VEC[v][1], VEC[v][0]);
      sendIdle(2);
      expectOne("R2/R3/R4/R5/R10 vector", c0, expD, 1'b0,
                cfgParityEn && VEC[v][1], VEC[v][0]);
    end

    // R5: line held low after a bad stop gives no second character
    {cfgLongChar, cfgParityEn, cfgParityEven, cfgTwoStop} = 4'b1000;
    c0 = gotCount;
    sendFrame(8'hF0, 1'b0, 1'b0, 1'b1);
    rxd = 1'b0;
    bitWait(3);
    sendIdle(2);
    expectOne("R5", c0, 8'hF0, 1'b0, 1'b0, 1'b1);
    c0 = gotCount;
    sendFrame(8'h0F, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R5", c0, 8'h0F, 1'b0, 1'b0, 1'b0);

    // R11: outputs hold after the strobe
    sendIdle(3);
    check("R11", rxData == 8'h0F, rxData, 8'h0F);
    check("R11", pulseBad == 0, pulseBad, 0);

    // R9: hunt command drops the next character
    pulseHunt();
    c0 = gotCount;
    sendFrame(8'h77, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectNone("R9", c0);

    // R6: shortest threshold 9 (7 bits, no parity, one stop)
    {cfgLongChar, cfgParityEn, cfgParityEven, cfgTwoStop} = 4'b0000;
    pulseHunt();
    sendIdle(8);
    c0 = gotCount;
    sendFrame(8'h12, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectNone("R6 short run 8", c0);
    pulseHunt();
    sendIdle(10);
    c0 = gotCount;
    sendFrame(8'h34, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R6 run 10", c0, 8'h34, 1'b0, 1'b0, 1'b0);

    // R6: longest threshold 12 (8 bits, parity, two stops)
    {cfgLongChar, cfgParityEn, cfgParityEven, cfgTwoStop} = 4'b1101;
    pulseHunt();
    sendIdle(11);
    c0 = gotCount;
    sendFrame(8'h56, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectNone("R6 short run 11", c0);
    pulseHunt();
    sendIdle(13);
    c0 = gotCount;
    sendFrame(8'h9A, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R6 run 13", c0, 8'h9A, 1'b0, 1'b0, 1'b0);

    // R7: multidrop hunt ignores idle and data characters
    {cfgLongChar, cfgParityEn, cfgParityEven, cfgTwoStop} = 4'b1000;
    cfgMultidrop = 1'b1;
    pulseHunt();
    sendIdle(20);
    c0 = gotCount;
    sendFrame(8'hAB, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectNone("R7 data in hunt", c0);
    c0 = gotCount;
    sendFrame(8'h42, 1'b1, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R7 address wakes", c0, 8'h42, 1'b1, 1'b0, 1'b0);

    // R8: awake multidrop delivers both kinds
    c0 = gotCount;
    sendFrame(8'h99, 1'b0, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R8 data", c0, 8'h99, 1'b0, 1'b0, 1'b0);
    // R3: parity covers the address bit too
    cfgParityEn = 1'b1;
    c0 = gotCount;
    sendFrame(8'h03, 1'b1, 1'b0, 1'b0);
    sendIdle(1);
    expectOne("R3 R8 address with parity", c0, 8'h03, 1'b1, 1'b0, 1'b0);
    c0 = gotCount;
    sendFrame(8'h03, 1'b1, 1'b1, 1'b0);
    sendIdle(1);
    expectOne("R3 bad parity multidrop", c0, 8'h03, 1'b1, 1'b1, 1'b0);

    check("R11", pulseBad == 0, pulseBad, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule